// File: doc/BRIEF.md
# Composite Sync Noise Gate with Phase Comparison Window

This block sits between an active-low composite sync input and the digital phase comparator of a line-locked pixel clock loop. It runs on the pixel clock and resynchronises the incoming sync. Using the current pixel position from the line's horizontal counter, it lets a sync falling edge through only when that edge lands inside a programmable pixel window. Outside the window, noise and equalising pulses are dropped before they can disturb the loop.

The gated sync is then timed against the locally generated horizontal sync. For every matched pair of falling edges the block issues a one-cycle comparison strobe together with a signed pixel-clock phase error. During acquisition the window can be opened completely by programming the start value beyond the line length and the stop value inside it. An optional phase-limit mode then accepts a comparison only when both syncs are low together, and it clips the reported error to a short programmable span. As a result, half-line serration pulses that come and go while the generated sync is still high produce no comparison.

Top module: `sync_gate_pd`

## Requirements
- R1: While `rst_n` is low at a clock edge, `gsync_n` becomes 1, `cmp_en` becomes 0 and `phase_err` becomes 0.
- R2: When `gate_start <= gate_stop`, a falling edge of the synchronised sync reaches `gsync_n` only if `gate_start <= hcount < gate_stop`. With equal values nothing passes.
- R3: When `gate_start > gate_stop` and the gate is not transparent, the window wraps: a falling edge passes only if `hcount >= gate_start` or `hcount < gate_stop`.
- R4: When `gate_start > line_len` and `gate_stop < line_len`, the gate is transparent and a falling edge passes at every `hcount`.
- R5: A rising edge of the synchronised sync always returns `gsync_n` high, at any position. A low that began outside the window never shows on `gsync_n`, even when the counter later enters the window.
- R6: If `csync_n_in` is first low at clock edge k and the edge passes, `gsync_n` goes low at edge k+2. It is still high after edge k+1.
- R7: Outside phase-limit mode, each pair of falling edges (gated sync, generated sync) gives exactly one single-cycle `cmp_en` pulse. `phase_err` equals the number of pixel clocks by which the gated sync fall lags the generated sync fall. The value is positive when the gated sync is later and negative when it is earlier.
- R8: Phase limiting is active when `limit_perm` is 1, or when `limit_en` is 1 while the gate is transparent. It is inactive otherwise.
- R9: With phase limiting active, the magnitude of `phase_err` is clipped to `win_len` (5 bits).
- R10: With phase limiting active, if the signal that fell first returns high before the other one falls, no comparison is made.
- R11: Falling edges of both syncs seen in the same cycle give a strobe with `phase_err` = 0.
- R12: `phase_err` holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csync_n_in | input | 1 | Asynchronous active-low composite sync |
| hsync_gen_n | input | 1 | Locally generated active-low horizontal sync, clock-synchronous |
| hcount | input | HW (11) | Current pixel position in the line |
| gate_start | input | HW (11) | First pixel position of the gate window |
| gate_stop | input | HW (11) | Pixel position that closes the gate window (exclusive) |
| line_len | input | HW (11) | Pixels per line, used to detect the transparent setting |
| limit_en | input | 1 | Phase limiting while the gate is transparent |
| limit_perm | input | 1 | Phase limiting at all times |
| win_len | input | WW (5) | Phase-limit span in pixel clocks |
| gsync_n | output | 1 | Gated active-low sync |
| cmp_en | output | 1 | One-cycle comparison strobe |
| phase_err | output | CW+1 (11) | Signed phase error in pixel clocks, valid with `cmp_en` |

## Verification
The gate is driven with random pixel positions against ordinary, wrapped, empty and transparent windows. These cases separate a wrong bound, a swapped inclusive/exclusive end, and a wrong wrap or transparency rule. Edge pairs with random signed offsets are run in all four limit configurations, which distinguishes the lag sign, the clipping and the limit-enable rule. Directed runs add a coincident pair, a short serration pulse that must be dropped only in limit mode, and a sync low that starts outside the window and then drifts into it.

// File: rtl/sync_gate_pd_pkg.sv
// Shared types and helpers for the sync noise gate and phase comparator.
// Assumes pixel positions are unsigned and below 2**HW.
package sync_gate_pd_pkg;

    // Phase comparator states: which sync fell first in the pending pair
    typedef enum logic [1:0] {
        PD_IDLE    = 2'd0,
        PD_HS_LEAD = 2'd1,
        PD_GS_LEAD = 2'd2
    } pd_state_t;

    // Window membership for a plain or wrapped gate (transparency handled by caller)
    function automatic logic win_hit(input logic [15:0] pos,
                                     input logic [15:0] first,
                                     input logic [15:0] last);
        if (first <= last)
            return (pos >= first) && (pos < last);
        else
            return (pos >= first) || (pos < last);
    endfunction

endpackage

// File: rtl/sync_gate.sv
// Resynchronises the asynchronous composite sync and gates its falling edges
// by pixel position. Assumes hcount is synchronous to clk. A start value
// beyond line_len together with a stop value inside it opens the gate fully.
module sync_gate #(
    parameter int HW          = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csync_n_in,
    input  logic [HW-1:0] hcount,
    input  logic [HW-1:0] gate_start,
    input  logic [HW-1:0] gate_stop,
    input  logic [HW-1:0] line_len,
    output logic          gsync_n,
    output logic          transparent
);
    import sync_gate_pd_pkg::*;

    logic [SYNC_STAGES-1:0] sync_sh;
    logic                   csync_s;
    logic                   csync_d;
    logic                   fall_s;
    logic                   in_win;
    logic                   gs_q;

    // Synchroniser chain, one flop per stage
    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                // First stage samples the raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_sh[0] <= 1'b1;
                    else        sync_sh[0] <= csync_n_in;
                end
            end else begin : g_next
                // Later stages shift the sample along
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_sh[gi] <= 1'b1;
                    else        sync_sh[gi] <= sync_sh[gi-1];
                end
            end
        end
    endgenerate

    assign csync_s = sync_sh[SYNC_STAGES-1];

    // Previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) csync_d <= 1'b1;
        else        csync_d <= csync_s;
    end

    assign fall_s = csync_d & ~csync_s;

    // Window decode: transparency override, otherwise plain or wrapped window
    always_comb begin
        transparent = (gate_start > line_len) && (gate_stop < line_len);
        in_win      = transparent |
                      win_hit(16'(hcount), 16'(gate_start), 16'(gate_stop));
    end

    // Gated output: rises with the sync, falls only on an accepted edge
    always_ff @(posedge clk) begin
        if (!rst_n)                gs_q <= 1'b1;
        else if (csync_s)          gs_q <= 1'b1;
        else if (fall_s && in_win) gs_q <= 1'b0;
    end

    assign gsync_n = gs_q;

    AST_NO_FALL_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gsync_n) |-> $past(in_win)); // R2
    AST_TRANSPARENT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (transparent && fall_s) |=> !gsync_n); // R4
    AST_RISE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(csync_s) |=> gsync_n); // R5

endmodule

// File: rtl/phase_cmp.sv
// Times the gated sync against the generated horizontal sync, both active
// low. Assumes both inputs are synchronous to clk. Produces one strobe per
// matched pair of falling edges with a signed lag in pixel clocks. In limit
// mode, a pair is dropped if the leading sync rises early, and the lag is
// clipped to win_len.
module phase_cmp #(
    parameter int CW = 10,
    parameter int WW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gsync_n,
    input  logic                 hsync_gen_n,
    input  logic                 lim_act,
    input  logic [WW-1:0]        win_len,
    output logic                 cmp_en,
    output logic signed [CW:0]   phase_err
);
    import sync_gate_pd_pkg::*;

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    pd_state_t           st, st_n;
    logic [CW-1:0]       cnt, cnt_n;
    logic                hs_r, hs_d, gs_d;
    logic                hs_fall, gs_fall;
    logic                done;
    logic                neg;
    logic [CW-1:0]       mag;
    logic [CW-1:0]       win_ext;
    logic [CW-1:0]       cnt_sat;
    logic [CW-1:0]       cnt_inc;
    logic signed [CW:0]  err_val;
    logic [CW:0]         err_abs;

    // Input register and edge-detect history for both syncs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_r <= 1'b1;
            hs_d <= 1'b1;
            gs_d <= 1'b1;
        end else begin
            hs_r <= hsync_gen_n;
            hs_d <= hs_r;
            gs_d <= gsync_n;
        end
    end

    // Falling edges, clipped and incremented counts
    always_comb begin
        hs_fall = hs_d & ~hs_r;
        gs_fall = gs_d & ~gsync_n;
        win_ext = CW'(win_len);
        cnt_sat = (lim_act && (cnt > win_ext)) ? win_ext : cnt;
        cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
    end

    // Pair tracking: decide completion, abort or continued counting
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        done  = 1'b0;
        neg   = 1'b0;
        mag   = '0;
        unique case (st)
            PD_IDLE: begin
                if (gs_fall && hs_fall) begin
                    done = 1'b1;
                end else if (hs_fall) begin
                    st_n  = PD_HS_LEAD;
                    cnt_n = CW'(1);
                end else if (gs_fall) begin
                    st_n  = PD_GS_LEAD;
                    cnt_n = CW'(1);
                end
            end
            PD_HS_LEAD: begin
                if (gs_fall) begin
                    done = 1'b1;
                    mag  = cnt_sat;
                    st_n = PD_IDLE;
                end else if (lim_act && hs_r) begin
                    st_n = PD_IDLE;
                end else if (hs_fall) begin
                    cnt_n = CW'(1);
                end else begin
                    cnt_n = cnt_inc;
                end
            end
            PD_GS_LEAD: begin
                if (hs_fall) begin
                    done = 1'b1;
                    neg  = 1'b1;
                    mag  = cnt_sat;
                    st_n = PD_IDLE;
                end else if (lim_act && gsync_n) begin
                    st_n = PD_IDLE;
                end else if (gs_fall) begin
                    cnt_n = CW'(1);
                end else begin
                    cnt_n = cnt_inc;
                end
            end
            default: st_n = PD_IDLE;
        endcase
        err_val = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end

    // State and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= PD_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // Strobe and held error output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_en    <= 1'b0;
            phase_err <= '0;
        end else begin
            cmp_en <= done;
            if (done) phase_err <= err_val;
        end
    end

    assign err_abs = phase_err[CW] ? (~phase_err + 1'b1) : phase_err;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_en |=> !cmp_en); // R7
    AST_LIMIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && $past(lim_act)) |-> (err_abs <= {1'b0, $past(win_ext)})); // R9
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |-> $stable(phase_err)); // R12

endmodule

// File: rtl/sync_gate_pd.sv
// Top level: composite sync noise gate followed by the windowed phase
// comparator. Assumes all inputs except csync_n_in are synchronous to clk.
module sync_gate_pd #(
    parameter int HW          = 11,
    parameter int CW          = 10,
    parameter int WW          = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csync_n_in,
    input  logic                hsync_gen_n,
    input  logic [HW-1:0]       hcount,
    input  logic [HW-1:0]       gate_start,
    input  logic [HW-1:0]       gate_stop,
    input  logic [HW-1:0]       line_len,
    input  logic                limit_en,
    input  logic                limit_perm,
    input  logic [WW-1:0]       win_len,
    output logic                gsync_n,
    output logic                cmp_en,
    output logic signed [CW:0]  phase_err
);

    logic transparent;
    logic lim_act;

    sync_gate #(.HW(HW), .SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .csync_n_in (csync_n_in),
        .hcount     (hcount),
        .gate_start (gate_start),
        .gate_stop  (gate_stop),
        .line_len   (line_len),
        .gsync_n    (gsync_n),
        .transparent(transparent)
    );

    // Limit mode: permanent, or enabled while acquiring with the gate open
    always_comb lim_act = limit_perm | (limit_en & transparent);

    phase_cmp #(.CW(CW), .WW(WW)) u_pd (
        .clk        (clk),
        .rst_n      (rst_n),
        .gsync_n    (gsync_n),
        .hsync_gen_n(hsync_gen_n),
        .lim_act    (lim_act),
        .win_len    (win_len),
        .cmp_en     (cmp_en),
        .phase_err  (phase_err)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (gsync_n && !cmp_en && (phase_err == 0))); // R1

endmodule

// File: tb/sync_gate_pd_tb.sv
`timescale 1ns/1ps
module sync_gate_pd_tb;
    localparam int HW = 11;
    localparam int CW = 10;
    localparam int WW = 5;
    localparam int LINE = 800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csync_n_in = 1'b1;
    logic hsync_gen_n = 1'b1;
    logic [HW-1:0] hcount = '0;
    logic [HW-1:0] gate_start = '0;
    logic [HW-1:0] gate_stop = '0;
    logic [HW-1:0] line_len = HW'(LINE);
    logic limit_en = 1'b0;
    logic limit_perm = 1'b0;
    logic [WW-1:0] win_len = 5'd15;
    logic gsync_n;
    logic cmp_en;
    logic signed [CW:0] phase_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sync_gate_pd #(.HW(HW), .CW(CW), .WW(WW)) u_dut (
        .clk(clk), .rst_n(rst_n), .csync_n_in(csync_n_in),
        .hsync_gen_n(hsync_gen_n), .hcount(hcount), .gate_start(gate_start),
        .gate_stop(gate_stop), .line_len(line_len), .limit_en(limit_en),
        .limit_perm(limit_perm), .win_len(win_len), .gsync_n(gsync_n),
        .cmp_en(cmp_en), .phase_err(phase_err));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected gate decision from R2/R3/R4
    function automatic bit exp_pass(input int h, input int s, input int e, input int len);
        if (s > len && e < len) return 1'b1;
        if (s <= e) return (h >= s) && (h < e);
        return (h >= s) || (h < e);
    endfunction

    // Expected error from R7/R9
    function automatic int exp_err(input int d, input bit lim, input int win);
        if (lim && d > win) return win;
        if (lim && d < -win) return -win;
        return d;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        csync_n_in = 1'b1;
        hsync_gen_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Gate test: short sync low pulse at fixed position, watch gsync_n
    task automatic gate_case(input int h, input int s, input int e, input string req);
        bit seen_low = 1'b0;
        do_reset();
        hcount = HW'(h);
        gate_start = HW'(s);
        gate_stop = HW'(e);
        csync_n_in = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (!gsync_n) seen_low = 1'b1;
        end
        csync_n_in = 1'b1;
        repeat (4) @(negedge clk);
        check(seen_low == exp_pass(h, s, e, LINE), req, int'(seen_low),
              int'(exp_pass(h, s, e, LINE)));
    endtask

    // Pair test: gated sync fall lags generated sync fall by d cycles
    task automatic pair_case(input int d, input int low_len, input bit en, input bit perm,
                             input bit transp, input int win, input bit exp_strobe,
                             input int exp_v, input string req);
        int tg, th, sc, ce, total, n, v;
        do_reset();
        hcount = HW'(50);
        if (transp) begin gate_start = HW'(LINE + 10); gate_stop = HW'(5); end
        else        begin gate_start = HW'(0);         gate_stop = HW'(LINE); end
        limit_en = en;
        limit_perm = perm;
        win_len = WW'(win);
        tg = 12 + ((d > 0) ? d : 0);
        th = tg - d;
        sc = tg - 2;
        ce = (low_len > 0) ? sc + low_len : 1000000;
        total = ((tg > th) ? tg : th) + 30;
        n = 0;
        v = 0;
        for (int s = 0; s < total; s++) begin
            csync_n_in = !((s >= sc) && (s < ce));
            hsync_gen_n = !(s >= th);
            @(posedge clk);
            @(negedge clk);
            if (cmp_en) begin n++; v = int'(phase_err); end
        end
        check(n == (exp_strobe ? 1 : 0), {req, " strobe count"}, n, exp_strobe ? 1 : 0);
        if (exp_strobe) check(v == exp_v, {req, " phase error"}, v, exp_v);
        csync_n_in = 1'b1;
        hsync_gen_n = 1'b1;
        repeat (10) @(negedge clk);
        if (exp_strobe) check(int'(phase_err) == v, "R12 error held", int'(phase_err), v);
        limit_en = 1'b0;
        limit_perm = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state
        repeat (3) @(negedge clk);
        check(gsync_n == 1'b1, "R1 gsync_n", int'(gsync_n), 1);
        check(cmp_en == 1'b0, "R1 cmp_en", int'(cmp_en), 0);
        check(phase_err == 0, "R1 phase_err", int'(phase_err), 0);
        rst_n = 1'b1;

        // R6: latency through the synchroniser and gate (transparent)
        do_reset();
        gate_start = HW'(LINE + 10);
        gate_stop = HW'(5);
        csync_n_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(gsync_n == 1'b1, "R6 still high after k+1", int'(gsync_n), 1);
        @(negedge clk);
        check(gsync_n == 1'b0, "R6 low after k+2", int'(gsync_n), 0);
        csync_n_in = 1'b1;

        // R2 directed: bounds and empty window
        gate_case(100, 100, 200, "R2 start inclusive");
        gate_case(200, 100, 200, "R2 stop exclusive");
        gate_case(99, 100, 200, "R2 below start");
        gate_case(150, 150, 150, "R2 empty window");
        // R3 directed: wrapped window
        gate_case(750, 700, 40, "R3 wrap high side");
        gate_case(10, 700, 40, "R3 wrap low side");
        gate_case(300, 700, 40, "R3 wrap outside");
        // R4 directed: transparent
        gate_case(300, LINE + 10, 40, "R4 transparent mid");
        gate_case(LINE - 1, LINE + 10, 40, "R4 transparent end");
        // Random gate cases
        for (int i = 0; i < 30; i++) begin
            int h = int'($urandom_range(LINE - 1, 0));
            int s = int'($urandom_range(LINE + 40, 0));
            int e = int'($urandom_range(LINE + 40, 0));
            gate_case(h, s, e, "R2 R3 R4 random gate");
        end

        // R5: low beginning outside window never appears; rise releases anywhere
        do_reset();
        gate_start = HW'(100);
        gate_stop = HW'(200);
        hcount = HW'(500);
        csync_n_in = 1'b0;
        repeat (5) @(negedge clk);
        hcount = HW'(150);
        repeat (5) @(negedge clk);
        check(gsync_n == 1'b1, "R5 late low blocked", int'(gsync_n), 1);
        csync_n_in = 1'b1;
        repeat (4) @(negedge clk);
        csync_n_in = 1'b0;
        repeat (5) @(negedge clk);
        check(gsync_n == 1'b0, "R5 inside low passes", int'(gsync_n), 0);
        hcount = HW'(500);
        csync_n_in = 1'b1;
        repeat (4) @(negedge clk);
        check(gsync_n == 1'b1, "R5 rise outside window", int'(gsync_n), 1);

        // R7: unlimited lag sign and value
        pair_case(7, 0, 1'b0, 1'b0, 1'b1, 15, 1'b1, 7, "R7 late sync");
        pair_case(-9, 0, 1'b0, 1'b0, 1'b1, 15, 1'b1, -9, "R7 early sync");
        pair_case(25, 0, 1'b0, 1'b0, 1'b1, 15, 1'b1, 25, "R7 beyond span unlimited");
        // R11: coincident falls
        pair_case(0, 0, 1'b0, 1'b0, 1'b1, 15, 1'b1, 0, "R11 coincident");
        // R8: limit enable only counts with transparent gate
        pair_case(25, 0, 1'b1, 1'b0, 1'b0, 15, 1'b1, 25, "R8 enable with gate active");
        pair_case(25, 0, 1'b1, 1'b0, 1'b1, 15, 1'b1, 15, "R8 enable with gate open");
        pair_case(-25, 0, 1'b0, 1'b1, 1'b0, 15, 1'b1, -15, "R8 permanent limit");
        // R9: clipping at a small span
        pair_case(12, 0, 1'b0, 1'b1, 1'b1, 4, 1'b1, 4, "R9 clip positive");
        pair_case(3, 0, 1'b0, 1'b1, 1'b1, 4, 1'b1, 3, "R9 inside span");
        // R10: serration pulse dropped in limit mode, measured otherwise
        pair_case(-30, 4, 1'b0, 1'b1, 1'b1, 15, 1'b0, 0, "R10 serration dropped");
        pair_case(-30, 4, 1'b0, 1'b0, 1'b1, 15, 1'b1, -30, "R10 serration unlimited");
        // Random pairs across limit configurations
        for (int i = 0; i < 24; i++) begin
            int d = int'($urandom_range(60, 0)) - 30;
            bit en = 1'($urandom_range(1, 0));
            bit pm = 1'($urandom_range(1, 0));
            bit tr = 1'($urandom_range(1, 0));
            int w = int'($urandom_range(31, 0));
            bit lim = pm | (en & tr);
            pair_case(d, 0, en, pm, tr, w, 1'b1, exp_err(d, lim, w), "R7 R8 R9 random pair");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule